// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one processor core. It holds three bit arrays with one bit per vector: a pending array, an in-service array and a trigger-kind array. Requests arrive as a vector number with a level/edge flag. The block works out a processor priority from the task-priority register and the highest vector in service. From that priority it raises an interrupt line whenever a pending vector may interrupt the current work.

The core answers the line with a one-cycle acknowledge strobe. One cycle later the block returns one of three results: the granted vector, the spurious vector when the pending work is masked by priority, or no vector. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered and directed end-of-interrupt is off, the block sends out a one-cycle broadcast pulse carrying the vector so that the source can re-arm. Software sets the task priority either as a full byte or as a 4-bit class, and sets the spurious/enable register.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, all three arrays are empty, task priority, processor priority and the spurious register read zero, and `irq`, `ack_done` and `eoi_bcast` are low.
- R2: A request sets the vector's pending bit. It also sets the trigger-kind bit when `req_level` is 1 and clears it when `req_level` is 0; a later request for the same vector overwrites that bit. The trigger kind shows up only in whether end-of-interrupt broadcasts.
- R3: The top pending vector and the top in-service vector are each the highest-numbered set bit of their array. An acknowledge always grants the top pending vector.
- R4: `ppr_q` equals `tpr_q` when bits 7:4 of `tpr_q` are at least the class (bits 7:4) of the top in-service vector, or when nothing is in service. Otherwise it equals that in-service class followed by four zero bits.
- R5: `irq` is high exactly when the enable bit (bit 8 of the spurious register) is set, some vector is pending, and either `ppr_q` is zero or the top pending vector's class is strictly greater than the class of `ppr_q`.
- R6: While the enable bit is clear, `irq` stays low. An acknowledge then answers with `ack_vld` low and leaves the pending array untouched.
- R7: An acknowledge while enabled, with a vector pending but not allowed through by R5, answers `ack_vld` high with `ack_vec` equal to bits 7:0 of the spurious register, and changes no state.
- R8: An acknowledge that R5 allows answers with the top pending vector, clears its pending bit and sets its in-service bit, so `ppr_q` follows R4 with the new vector in service.
- R9: End-of-interrupt clears the top in-service bit. It pulses `eoi_bcast` with `eoi_vec` equal to that vector only when the vector's trigger-kind bit is set and the directed bit (bit 12 of the spurious register) is clear. With nothing in service it does nothing.
- R10: A spurious-register write keeps bits 8:0 and bit 12 and clears all other bits. A full task-priority write stores the byte unchanged. A class write stores its 4-bit value in bits 7:4 with zeros below, and the full write wins if both are strobed together.
- R11: `ack_done` pulses in the cycle after each `ack_req` and at no other time. `irq` and `ppr_q` reflect a state change in the cycle right after the clock edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered request, 0 = edge |
| ack_req | input | 1 | Acknowledge strobe from the core |
| ack_done | output | 1 | Acknowledge answer valid (one cycle) |
| ack_vld | output | 1 | A vector is returned with the answer |
| ack_vec | output | 8 | Granted or spurious vector |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec | output | 8 | Vector carried by the broadcast |
| tpr_we | input | 1 | Full task-priority write |
| tpr_wdata | input | 8 | Full task-priority value |
| tpr_cls_we | input | 1 | Task-priority class write |
| tpr_cls_wdata | input | 4 | Class value, stored in bits 7:4 |
| svr_we | input | 1 | Spurious/enable register write |
| svr_wdata | input | 16 | Spurious/enable write data |
| tpr_q | output | 8 | Current task priority |
| svr_q | output | 16 | Current spurious/enable register |
| ppr_q | output | 8 | Current processor priority |
| irq | output | 1 | Deliverable interrupt present |

## Verification
The bench builds the block with its default of 256 vectors, so vectors are 8 bits wide and there are 16 priority classes. That puts the boundaries within reach: vector 255 with class 15 as the top in-service vector, and class-0 vectors that can be delivered only through the zero-priority rule. It also covers vectors of equal and adjacent classes, where the strict comparison decides, and both the task-priority and in-service sides of the priority maximum. The directed bit sits inside the 16-bit write path, so both broadcast outcomes of a level vector and the masking of the other bits can be driven through ports.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  // bits per priority class field (vector bits above this form the class)
  localparam int CLASS_SHIFT = 4;
  localparam int SVR_W       = 16;
  localparam int SVR_EN_BIT  = 8;
  localparam int SVR_DIR_BIT = 12;
  localparam logic [SVR_W-1:0] SVR_KEEP =
    (SVR_W'(1) << SVR_DIR_BIT) | SVR_W'(16'h01FF);

  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_SPUR  = 2'd1,
    ACK_GRANT = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = IW'(i);
    end
    any_o = |bits_i;
  end
endmodule

// File: rtl/vpc_prio_eval.sv
module vpc_prio_eval
  import vpc_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int CLS_W = VEC_W - CLASS_SHIFT
) (
  input  logic             enable_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_top_i,
  input  logic             irr_any_i,
  input  logic [VEC_W-1:0] irr_top_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             deliver_o,
  output logic             blocked_o
);
  logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;

  always_comb begin
    isr_cls = isr_any_i ? isr_top_i[VEC_W-1:CLASS_SHIFT] : '0;
    tpr_cls = tpr_i[VEC_W-1:CLASS_SHIFT];
    irr_cls = irr_top_i[VEC_W-1:CLASS_SHIFT];
    if (tpr_cls >= isr_cls) ppr_o = tpr_i;
    else                    ppr_o = {isr_cls, {CLASS_SHIFT{1'b0}}};
    ppr_cls   = ppr_o[VEC_W-1:CLASS_SHIFT];
    deliver_o = enable_i && irr_any_i && ((ppr_o == '0) || (irr_cls > ppr_cls));
    blocked_o = enable_i && irr_any_i && !deliver_o;
  end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VEC = 256,
  localparam int VEC_W = $clog2(NUM_VEC),
  localparam int CLS_W = VEC_W - CLASS_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             req_level,
  input  logic             ack_req,
  output logic             ack_done,
  output logic             ack_vld,
  output logic [VEC_W-1:0] ack_vec,
  input  logic             eoi_req,
  output logic             eoi_bcast,
  output logic [VEC_W-1:0] eoi_vec,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             tpr_cls_we,
  input  logic [CLS_W-1:0] tpr_cls_wdata,
  input  logic             svr_we,
  input  logic [SVR_W-1:0] svr_wdata,
  output logic [VEC_W-1:0] tpr_q,
  output logic [SVR_W-1:0] svr_q,
  output logic [VEC_W-1:0] ppr_q,
  output logic             irq
);
  // state
  logic [NUM_VEC-1:0] irr_r, isr_r, tmr_r;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0]   tpr_r, tpr_n;
  logic [SVR_W-1:0]   svr_r, svr_n;

  // decoded strobes
  logic [NUM_VEC-1:0] ack_set, req_set, eoi_clr;
  logic irr_any, isr_any, deliver, blocked;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic state_en, tpr_en;
  ack_kind_e ack_kind;

  logic             done_n, vld_n, bc_n;
  logic [VEC_W-1:0] vec_n, bvec_n;

  vpc_msb_find #(.N(NUM_VEC)) u_irr_find (.bits_i(irr_r), .any_o(irr_any), .idx_o(irr_top));
  vpc_msb_find #(.N(NUM_VEC)) u_isr_find (.bits_i(isr_r), .any_o(isr_any), .idx_o(isr_top));

  vpc_prio_eval #(.VEC_W(VEC_W)) u_eval (
    .enable_i (svr_r[SVR_EN_BIT]),
    .tpr_i    (tpr_r),
    .isr_any_i(isr_any),
    .isr_top_i(isr_top),
    .irr_any_i(irr_any),
    .irr_top_i(irr_top),
    .ppr_o    (ppr_q),
    .deliver_o(deliver),
    .blocked_o(blocked)
  );

  // next state
  always_comb begin
    if (ack_req && deliver)      ack_kind = ACK_GRANT;
    else if (ack_req && blocked) ack_kind = ACK_SPUR;
    else                         ack_kind = ACK_NONE;

    ack_set = '0;
    if (ack_kind == ACK_GRANT) ack_set[irr_top] = 1'b1;
    req_set = '0;
    if (req_valid) req_set[req_vec] = 1'b1;
    eoi_clr = '0;
    if (eoi_req && isr_any) eoi_clr[isr_top] = 1'b1;

    // a same-cycle request survives a grant of the same vector
    irr_n = (irr_r & ~ack_set) | req_set;
    isr_n = (isr_r & ~eoi_clr) | ack_set;
    tmr_n = tmr_r;
    if (req_valid) tmr_n[req_vec] = req_level;

    if (tpr_we) tpr_n = tpr_wdata;
    else        tpr_n = {tpr_cls_wdata, {CLASS_SHIFT{1'b0}}};
    svr_n = svr_wdata & SVR_KEEP;

    state_en = req_valid || (ack_kind == ACK_GRANT) || eoi_req;
    tpr_en   = tpr_we || tpr_cls_we;

    done_n = ack_req;
    vld_n  = (ack_kind != ACK_NONE);
    case (ack_kind)
      ACK_GRANT: vec_n = irr_top;
      ACK_SPUR:  vec_n = svr_r[VEC_W-1:0];
      default:   vec_n = '0;
    endcase

    bc_n   = eoi_req && isr_any && tmr_r[isr_top] && !svr_r[SVR_DIR_BIT];
    bvec_n = bc_n ? isr_top : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_r <= '0;
      isr_r <= '0;
      tmr_r <= '0;
    end else if (state_en) begin
      irr_r <= irr_n;
      isr_r <= isr_n;
      tmr_r <= tmr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_r <= '0;
    else if (tpr_en) tpr_r <= tpr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svr_r <= '0;
    else if (svr_we) svr_r <= svr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_done  <= 1'b0;
      ack_vld   <= 1'b0;
      ack_vec   <= '0;
      eoi_bcast <= 1'b0;
      eoi_vec   <= '0;
    end else begin
      ack_done  <= done_n;
      ack_vld   <= vld_n;
      ack_vec   <= vec_n;
      eoi_bcast <= bc_n;
      eoi_vec   <= bvec_n;
    end
  end

  assign tpr_q = tpr_r;
  assign svr_q = svr_r;
  assign irq   = deliver;
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk
  import vpc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_req,
  input logic             ack_done,
  input logic             ack_vld,
  input logic             eoi_req,
  input logic             eoi_bcast,
  input logic [VEC_W-1:0] tpr_q,
  input logic [SVR_W-1:0] svr_q,
  input logic [VEC_W-1:0] ppr_q,
  input logic             irq
);
  // R6
  irq_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svr_q[SVR_EN_BIT] |-> !irq);

  // R6
  ack_empty_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !svr_q[SVR_EN_BIT]) |=> !ack_vld);

  // R11
  ack_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_done);

  // R11
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_done);

  // R7
  ack_vld_in_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> ack_done);

  // R4
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_q >= tpr_q);

  // R9
  bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_req |=> !eoi_bcast);

  // R10
  svr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svr_q & ~SVR_KEEP) == '0);
endmodule

bind vec_prio_ctrl vpc_chk #(.VEC_W(VEC_W)) u_vpc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_req  (ack_req),
  .ack_done (ack_done),
  .ack_vld  (ack_vld),
  .eoi_req  (eoi_req),
  .eoi_bcast(eoi_bcast),
  .tpr_q    (tpr_q),
  .svr_q    (svr_q),
  .ppr_q    (ppr_q),
  .irq      (irq)
);

// File: tb/vec_prio_ctrl_bench.sv
module vec_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] OP_REQ = 3'd0;
  localparam logic [2:0] OP_ACK = 3'd1;
  localparam logic [2:0] OP_EOI = 3'd2;
  localparam logic [2:0] OP_TPR = 3'd3;
  localparam logic [2:0] OP_CLS = 3'd4;
  localparam logic [2:0] OP_SVR = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] arg;
    logic        lvl;
    logic        irq;
    logic        vld;
    logic [7:0]  vec;
    logic        bc;
    logic [7:0]  ppr;
  } step_t;

  localparam int NSTEP = 38;
  // op, arg, level, irq, ack_vld, vector (ack or broadcast), bcast, ppr
  localparam step_t TBL [NSTEP] = '{
    '{OP_REQ, 16'h0045, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 disabled, no irq
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 no vector
    '{OP_SVR, 16'hF1FF, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R10 directed set, enabled
    '{OP_REQ, 16'h0062, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R2 level
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h62, 1'b0, 8'h60}, // R3 R8
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h60}, // R7 spurious
    '{OP_EOI, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R9 directed: no bcast
    '{OP_SVR, 16'h01F0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_REQ, 16'h0062, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h62, 1'b0, 8'h60},
    '{OP_EOI, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h62, 1'b1, 8'h00}, // R9 level bcast
    '{OP_CLS, 16'h0005, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h50}, // R10 class write, R5 4<=5
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hF0, 1'b0, 8'h50}, // R7
    '{OP_TPR, 16'h0030, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h30},
    '{OP_REQ, 16'h0031, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h30},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h45, 1'b0, 8'h40}, // R3 R4 isr side wins
    '{OP_REQ, 16'h0080, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h40},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 8'h80},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h40}, // R9 edge: no bcast
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h30}, // R4 tpr side, R5 3 not > 3
    '{OP_TPR, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h31, 1'b0, 8'h30},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R9 empty ignored
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // nothing pending
    '{OP_REQ, 16'h0005, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R5 class 0, ppr zero
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h05, 1'b0, 8'h00},
    '{OP_REQ, 16'h0003, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 8'h00},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_REQ, 16'h00FF, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // top vector
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'hF0},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h00},
    '{OP_REQ, 16'h0070, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R2 level then edge
    '{OP_REQ, 16'h0070, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    '{OP_ACK, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h70, 1'b0, 8'h70},
    '{OP_EOI, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}  // R2 trigger cleared
  };

  logic        clk, rst_n;
  logic        req_valid, req_level, ack_req, eoi_req;
  logic [7:0]  req_vec;
  logic        ack_done, ack_vld, eoi_bcast, irq;
  logic [7:0]  ack_vec, eoi_vec, tpr_q, ppr_q;
  logic        tpr_we, tpr_cls_we, svr_we;
  logic [7:0]  tpr_wdata;
  logic [3:0]  tpr_cls_wdata;
  logic [15:0] svr_wdata, svr_q;

  int n_run, n_fail;
  bit done;

  vec_prio_ctrl u_vec_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
    .ack_req(ack_req), .ack_done(ack_done), .ack_vld(ack_vld), .ack_vec(ack_vec),
    .eoi_req(eoi_req), .eoi_bcast(eoi_bcast), .eoi_vec(eoi_vec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .tpr_cls_we(tpr_cls_we), .tpr_cls_wdata(tpr_cls_wdata),
    .svr_we(svr_we), .svr_wdata(svr_wdata),
    .tpr_q(tpr_q), .svr_q(svr_q), .ppr_q(ppr_q), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_vec = '0; req_level = 0; ack_req = 0; eoi_req = 0;
    tpr_we = 0; tpr_wdata = '0; tpr_cls_we = 0; tpr_cls_wdata = '0;
    svr_we = 0; svr_wdata = '0;
  endtask

  // drive one operation for one cycle; returns at the negedge after the edge
  task automatic do_op(input logic [2:0] op, input logic [15:0] arg, input logic lvl);
    @(negedge clk);
    case (op)
      OP_REQ: begin req_valid = 1; req_vec = arg[7:0]; req_level = lvl; end
      OP_ACK: ack_req = 1;
      OP_EOI: eoi_req = 1;
      OP_TPR: begin tpr_we = 1; tpr_wdata = arg[7:0]; end
      OP_CLS: begin tpr_cls_we = 1; tpr_cls_wdata = arg[3:0]; end
      default: begin svr_we = 1; svr_wdata = arg; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 ppr", 32'(ppr_q), 0);
    check("R1 tpr", 32'(tpr_q), 0);
    check("R1 svr", 32'(svr_q), 0);
    check("R1 ack_done", 32'(ack_done), 0);
    check("R1 eoi_bcast", 32'(eoi_bcast), 0);

    for (int s = 0; s < NSTEP; s++) begin
      do_op(TBL[s].op, TBL[s].arg, TBL[s].lvl);
      check($sformatf("R5 irq step %0d", s), 32'(irq), 32'(TBL[s].irq));
      check($sformatf("R4 ppr step %0d", s), 32'(ppr_q), 32'(TBL[s].ppr));
      check($sformatf("R11 ack_done step %0d", s), 32'(ack_done), 32'(TBL[s].op == OP_ACK));
      if (TBL[s].op == OP_ACK) begin
        check($sformatf("R8 ack_vld step %0d", s), 32'(ack_vld), 32'(TBL[s].vld));
        if (TBL[s].vld) check($sformatf("R8 ack_vec step %0d", s), 32'(ack_vec), 32'(TBL[s].vec));
      end
      check($sformatf("R9 eoi_bcast step %0d", s), 32'(eoi_bcast), 32'(TBL[s].bc));
      if (TBL[s].bc) check($sformatf("R9 eoi_vec step %0d", s), 32'(eoi_vec), 32'(TBL[s].vec));
    end

    // R10 register write shaping
    do_op(OP_SVR, 16'hFFFF, 0);
    check("R10 svr mask", 32'(svr_q), 32'h11FF);
    do_op(OP_CLS, 16'h000A, 0);
    check("R10 class write", 32'(tpr_q), 32'hA0);
    do_op(OP_TPR, 16'h0037, 0);
    check("R10 full write", 32'(tpr_q), 32'h37);
    @(negedge clk);
    tpr_we = 1; tpr_wdata = 8'h12; tpr_cls_we = 1; tpr_cls_wdata = 4'h9;
    @(negedge clk);
    idle_inputs();
    check("R10 full write wins", 32'(tpr_q), 32'h12);
    do_op(OP_TPR, 16'h0000, 0);

    // R6 disabled keeps pending state
    do_op(OP_SVR, 16'h0000, 0);
    do_op(OP_REQ, 16'h0022, 0);
    check("R6 irq disabled", 32'(irq), 0);
    do_op(OP_ACK, 16'h0000, 0);
    check("R6 ack_done", 32'(ack_done), 1);
    check("R6 ack_vld", 32'(ack_vld), 0);
    do_op(OP_SVR, 16'h0100, 0);
    check("R6 pending kept", 32'(irq), 1);
    do_op(OP_ACK, 16'h0000, 0);
    check("R6 R3 grant after enable", 32'(ack_vec), 32'h22);
    check("R8 ppr after grant", 32'(ppr_q), 32'h20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule